// File: doc/BRIEF.md
# Spline-Driven Sinusoid Amplitude and Phase Generator

This block produces the two control words that steer one sinusoid channel: a 16-bit amplitude that follows a cubic polynomial in time and a 16-bit phase, in turns, that follows a quadratic polynomial in time. Both curves advance once per clock (8 ns at the intended rate) by forward differencing, so only additions are needed. A later rotation stage, outside this block, turns these words into the waveform and carries a fixed gain of about 1.64676, so the amplitude word is scaled by that factor downstream.

Coefficients reach the block as 16-bit word writes, each aimed at a word index, into a pending buffer that has no effect on the outputs. A single trigger pulse copies the whole buffer into the running generators in one cycle. A clear input, sampled with the trigger, chooses whether the phase restarts at the loaded start phase or carries on from where it was, with only its rate terms replaced.

Top module: `spl_dds_engine`

## Requirements
- R1: During and after reset both outputs read zero and every pending word is zero, so a trigger right after reset keeps both outputs at zero.
- R2: Word index map: 0 holds the amplitude start value; 1 and 2 hold the low and high halves of the 32-bit first amplitude difference; 3, 4, 5 hold the low, middle and high parts of the 48-bit second difference; 6, 7, 8 the same for the 48-bit third difference; 9 holds the phase start; 10 and 11 the low and high halves of the 32-bit phase rate; 12 and 13 the low and high halves of the 32-bit phase acceleration. Writes to indices 14 and 15 change nothing.
- R3: Word writes without a trigger leave both outputs on their running course.
- R4: On the cycle after a trigger the amplitude output equals the start value. The amplitude runs in a 48-bit accumulator whose top 16 bits are the output: the start value sits in bits 47:32, the first difference in bits 47:16, and the second and third differences fill all 48 bits; each clock the accumulator adds the first difference, the first adds the second, and the second adds the third, all modulo 2^48.
- R5: The phase runs in a 32-bit accumulator whose top 16 bits are the output; each clock it adds the rate and the rate adds the acceleration, both modulo 2^32, so the phase wraps naturally through full turns.
- R6: A trigger with clear high sets the phase accumulator to the start phase in bits 31:16 with zero low bits, and loads rate and acceleration.
- R7: A trigger with clear low loads rate and acceleration but advances the phase accumulator by the old rate, ignoring the start phase word.
- R8: A trigger commits the buffer as it stood before that cycle; a word written in the same cycle is kept for the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one spline step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe into the pending buffer |
| wr_idx | input | 4 | Word index of the write |
| wr_data | input | 16 | Word value |
| trig | input | 1 | Commit pending coefficients this cycle |
| clr | input | 1 | With trig: restart phase at the start value when high |
| amp_out | output | 16 | Amplitude word, two's complement, before the downstream 1.64676 gain |
| phase_out | output | 16 | Phase word in turns (full scale is one turn) |

## Verification
The assertions assume that every input is a defined level at each rising edge and that the trigger and clear are single-cycle decisions sampled at that edge; nothing is assumed about how often the trigger comes or which word indices are written. The stimulus drives all inputs only at falling edges, keeps clear low whenever the trigger is low, and uses index values across the whole 4-bit range, including the two unused ones, so the write-ignore rule is exercised rather than avoided. Coefficient sets are picked with negative higher differences and with a phase rate of a quarter turn so that sign extension and accumulator wrap are both visited.

// File: rtl/spl_pkg.sv
package spl_pkg;
    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 14;
    localparam int IDX_W     = 4;
    localparam int AMP_W     = 48;
    localparam int PH_W      = 32;
    localparam int OUT_W     = 16;
    localparam int AD1_W     = 2 * WORD_W;
    localparam int PRATE_W   = 2 * WORD_W;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] word_bank_t;

    typedef struct packed {
        logic [WORD_W-1:0]  start;
        logic [AD1_W-1:0]   diff1;
        logic [AMP_W-1:0]   diff2;
        logic [AMP_W-1:0]   diff3;
    } amp_coef_t;

    typedef struct packed {
        logic [WORD_W-1:0]  start;
        logic [PRATE_W-1:0] rate;
        logic [PRATE_W-1:0] accel;
    } ph_coef_t;

    function automatic amp_coef_t pick_amp(input word_bank_t w);
        amp_coef_t c;
        c.start = w[0];
        c.diff1 = {w[2], w[1]};
        c.diff2 = {w[5], w[4], w[3]};
        c.diff3 = {w[8], w[7], w[6]};
        return c;
    endfunction

    function automatic ph_coef_t pick_phase(input word_bank_t w);
        ph_coef_t c;
        c.start = w[9];
        c.rate  = {w[11], w[10]};
        c.accel = {w[13], w[12]};
        return c;
    endfunction
endpackage

// File: rtl/spl_coef_buf.sv
module spl_coef_buf
    import spl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output word_bank_t        words
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                word_q <= wr_data;
        end
        assign words[i] = word_q;
    end

    // R2: indices past the map leave every word untouched
    p_unused_index_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && 32'(wr_idx) >= NUM_WORDS) |=> $stable(words));

    // R3: no strobe, no change in the pending buffer
    p_no_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(words));
endmodule

// File: rtl/spl_amp_cubic.sv
module spl_amp_cubic
    import spl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  amp_coef_t        coef,
    output logic [OUT_W-1:0] amp_out
);
    logic [AMP_W-1:0] acc, d1, d2, d3;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            d1  <= '0;
            d2  <= '0;
            d3  <= '0;
        end else if (load) begin
            acc <= {coef.start, {(AMP_W-WORD_W){1'b0}}};
            d1  <= {coef.diff1, {(AMP_W-AD1_W){1'b0}}};
            d2  <= coef.diff2;
            d3  <= coef.diff3;
        end else begin
            acc <= acc + d1;
            d1  <= d1 + d2;
            d2  <= d2 + d3;
        end
    end

    // Downstream rotation multiplies this word by about 1.64676.
    assign amp_out = acc[AMP_W-1 -: OUT_W];

    // R4: with all differences zero the amplitude holds
    p_flat_amp_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && d1 == '0 && d2 == '0 && d3 == '0) |=> $stable(amp_out));
endmodule

// File: rtl/spl_phase_quad.sv
module spl_phase_quad
    import spl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             restart,
    input  ph_coef_t         coef,
    output logic [OUT_W-1:0] phase_out
);
    logic [PH_W-1:0] acc, rate, accel;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            rate  <= '0;
            accel <= '0;
        end else if (load) begin
            acc   <= restart ? {coef.start, {(PH_W-WORD_W){1'b0}}} : acc + rate;
            rate  <= coef.rate;
            accel <= coef.accel;
        end else begin
            acc  <= acc + rate;
            rate <= rate + accel;
        end
    end

    assign phase_out = acc[PH_W-1 -: OUT_W];

    // R5: zero rate and acceleration freeze the phase
    p_flat_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && rate == '0 && accel == '0) |=> $stable(phase_out));
endmodule

// File: rtl/spl_dds_engine.sv
module spl_dds_engine
    import spl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              trig,
    input  logic              clr,
    output logic [OUT_W-1:0]  amp_out,
    output logic [OUT_W-1:0]  phase_out
);
    word_bank_t pend;
    amp_coef_t  amp_c;
    ph_coef_t   ph_c;

    spl_coef_buf u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .words(pend)
    );

    assign amp_c = pick_amp(pend);
    assign ph_c  = pick_phase(pend);

    spl_amp_cubic u_amp (
        .clk(clk), .rst(rst), .load(trig), .coef(amp_c), .amp_out(amp_out)
    );

    spl_phase_quad u_ph (
        .clk(clk), .rst(rst), .load(trig), .restart(clr),
        .coef(ph_c), .phase_out(phase_out)
    );

    // R4 / R8: commit shows the start value held before the trigger edge
    p_amp_commit_r4: assert property (@(posedge clk) disable iff (rst)
        trig |=> amp_out == $past(amp_c.start));

    // R6: clearing trigger restarts phase at the pending start word
    p_phase_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (trig && clr) |=> phase_out == $past(ph_c.start));
endmodule

// File: tb/test_spl_dds_engine.sv
module test_spl_dds_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        trig = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] amp_out, phase_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    logic [15:0] exp_amp[$];
    logic [15:0] exp_ph[$];
    int          exp_due[$];
    string       exp_tag[$];

    // reference state
    logic [47:0] mA, mD1, mD2, mD3;
    logic [31:0] mP, mF, mG;
    logic [15:0] mw [16];

    spl_dds_engine i_spl_dds_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .trig(trig), .clr(clr),
        .amp_out(amp_out), .phase_out(phase_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp_v, input string what);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp_v, cyc);
        end
    endtask

    // monitor: compare results that fall due after this cycle's edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_due.size() > 0 && exp_due[0] == cyc) begin
                check(exp_tag[0], amp_out, exp_amp[0], "amp");
                check(exp_tag[0], phase_out, exp_ph[0], "phase");
                void'(exp_amp.pop_front());
                void'(exp_ph.pop_front());
                void'(exp_due.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    // driver: apply one cycle of inputs, advance the model, queue the result
    task automatic step(input bit we, input int idx, input logic [15:0] d,
                        input bit tg, input bit cl, input string tag);
        wr_en = we; wr_idx = 4'(idx); wr_data = d; trig = tg; clr = cl;
        if (tg) begin
            mA  = {mw[0], 32'h0};
            mD1 = {mw[2], mw[1], 16'h0};
            mD2 = {mw[5], mw[4], mw[3]};
            mD3 = {mw[8], mw[7], mw[6]};
            mP  = cl ? {mw[9], 16'h0} : mP + mF;
            mF  = {mw[11], mw[10]};
            mG  = {mw[13], mw[12]};
        end else begin
            mA  = mA + mD1;
            mD1 = mD1 + mD2;
            mD2 = mD2 + mD3;
            mP  = mP + mF;
            mF  = mF + mG;
        end
        if (we && idx < 14) mw[idx] = d;
        exp_amp.push_back(mA[47:32]);
        exp_ph.push_back(mP[31:16]);
        exp_due.push_back(cyc + 1);
        exp_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 16'h0, 0, 0, tag);
    endtask

    task automatic load_set(input logic [15:0] ws [14], input string tag);
        for (int k = 0; k < 14; k++) step(1, k, ws[k], 0, 0, tag);
    endtask

    initial begin
        logic [15:0] set_a [14];
        mA = '0; mD1 = '0; mD2 = '0; mD3 = '0;
        mP = '0; mF = '0; mG = '0;
        for (int k = 0; k < 16; k++) mw[k] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", amp_out, 16'h0, "amp in reset");
        check("R1", phase_out, 16'h0, "phase in reset");
        rst = 1'b0;

        // R1: commit of an untouched buffer keeps zeros
        step(0, 0, 16'h0, 1, 1, "R1");
        idle(3, "R1");

        // R2/R3: full coefficient set, outputs stay put while loading
        set_a = '{16'h1000, 16'h8000, 16'h0001, 16'h0000, 16'hfff0, 16'hffff,
                  16'h1000, 16'h0000, 16'h0000, 16'h4000, 16'h0000, 16'h0100,
                  16'h2000, 16'h0000};
        load_set(set_a, "R3");
        step(1, 14, 16'hdead, 0, 0, "R2");
        step(1, 15, 16'hbeef, 0, 0, "R2");

        // R4/R5/R6: clearing commit, then free run
        step(0, 0, 16'h0, 1, 1, "R6");
        idle(20, "R4");

        // R7: new rates only, phase continues
        step(1, 10, 16'h8000, 0, 0, "R3");
        step(1, 11, 16'h0020, 0, 0, "R3");
        step(1, 9,  16'h7777, 0, 0, "R3");
        step(0, 0, 16'h0, 1, 0, "R7");
        idle(10, "R7");

        // R8: write in the trigger cycle waits for the next commit
        step(1, 0, 16'hc000, 1, 1, "R8");
        idle(4, "R8");
        step(0, 0, 16'h0, 1, 1, "R8");
        idle(4, "R8");

        // R5: quarter-turn rate wraps through full turns
        step(1, 10, 16'h0000, 0, 0, "R5");
        step(1, 11, 16'h4000, 0, 0, "R5");
        step(1, 12, 16'h0000, 0, 0, "R5");
        step(1, 13, 16'h0000, 0, 0, "R5");
        step(1, 9,  16'hf000, 0, 0, "R5");
        step(0, 0, 16'h0, 1, 1, "R5");
        idle(9, "R5");

        idle(2, "R4");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule